// File: doc/BRIEF.md
# OTP Page-Access Controller

This block is a register-mapped front end for a one-time-programmable storage array of 512 pages. Each page is 128 bits wide. Software sets a 16-bit byte mask and loads four 32-bit data registers. It then writes a command word that names a page and asks for a page write, a page read, or both. Only the bytes selected by the mask move between the data registers and the page. Unselected bytes keep their old value on both sides.

The array is modelled as ordinary synchronous storage with per-byte write enables. A one-request-at-a-time valid/ready bus carries a 2-bit access size. The block checks the size against the width of each register. Any access with the wrong width or to an address with no register is answered with an error response and changes no state. When a command finishes, the block sets a completion flag, which software clears by writing one.

Top module: `otp_page_ctrl`

## Requirements
- R1: After reset the command register reads 0x0000, the byte mask reads 0xFFFF, the status register reads 0x0000, the timing register reads 0x00001485 and all four data registers read 0.
- R2: The size code is 1 for a 16-bit access and 2 for a 32-bit access; codes 0 and 3 are always rejected. Command (0x00), byte mask (0x04) and status (0x08) accept only code 1. Timing (0x0C) and data words 0 to 3 (0x80, 0x84, 0x88, 0x8C) accept only code 2. A rejected access returns rsp_err=1 and rsp_rdata=0 and modifies no register.
- R3: Any address other than those eight, including the gap 0x10 to 0x7C and misaligned addresses, is rejected with rsp_err=1 and modifies no register.
- R4: A command write keeps only the bits under mask 0x39FF, and a later read of the command register returns exactly that value. Bits [8:0] name the page, bit 12 requests a page write and bit 13 requests a page read.
- R5: A page write copies each byte i of the data registers whose mask bit i is 1 into byte i of the addressed page; other page bytes are kept. Byte 0 is bits [7:0] of data word 0, and byte 15 is bits [31:24] of data word 3.
- R6: A page read copies each masked-in byte of the addressed page into the data registers; data bytes whose mask bit is 0 are left unchanged.
- R7: When both command bits are set, the page write completes before the page read, so the data registers end up holding the values just written.
- R8: Every accepted command write sets status bit 0, whether or not a command bit is set. Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: Each non-command access, including every rejected one, gets its response one cycle after acceptance. A command write gets its response four cycles after acceptance, and req_ready is low until that response.
- R10: All 16 byte-mask bits and all 32 timing bits are writable and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 8 | Byte offset of the register |
| req_size | input | 2 | Access size code (1 = 16-bit, 2 = 32-bit) |
| req_wdata | input | 32 | Write data, 16-bit values in bits [15:0] |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 32 | Read data, zero-extended for 16-bit registers |

## Verification
Every register access, good or rejected, is answered at the first falling edge after the accepting rising edge. A command write is answered at the fourth falling edge, after the array write cycle, the array read cycle and the merge cycle. The bench's access task counts falling edges from acceptance until the response pulse and compares that count with 1 or 4. It samples the response data and error only on that edge. Page contents are always checked by issuing a new command that reads them back and then reading the data registers, so every result is observed after the command response, never in between.

// File: rtl/otp_pkg.sv
// Shared constants and types for the OTP page controller.
// Assumes a 128-bit page split into sixteen byte lanes and four data words.
package otp_pkg;
    localparam int PAGE_BYTES = 16;
    localparam int WORD_W     = 32;
    localparam int DATA_WORDS = (PAGE_BYTES * 8) / WORD_W;
    localparam int NUM_REGS   = 4 + DATA_WORDS;

    // Register index positions in the one-hot select vector
    localparam int REG_CMD  = 0;
    localparam int REG_MASK = 1;
    localparam int REG_STAT = 2;
    localparam int REG_TIME = 3;
    localparam int REG_DAT0 = 4;

    // Command register layout
    localparam logic [15:0] CMD_KEEP_MASK = 16'h39FF;
    localparam int          CMD_WR_BIT    = 12;
    localparam int          CMD_RD_BIT    = 13;

    // Reset values
    localparam logic [15:0] MASK_RST = 16'hFFFF;
    localparam logic [31:0] TIME_RST = 32'h0000_1485;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PWR  = 2'd1,
        ST_PRD  = 2'd2,
        ST_LOAD = 2'd3
    } seq_state_e;
endpackage

// File: rtl/otp_reg_decode.sv
// Address and size decoder for the controller register bank.
// Produces a one-hot register select, or an error flag with no select.
// Assumes all registers are 4-byte aligned; a wrong size outranks a missing register.
module otp_reg_decode
    import otp_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_BASE = 8'h80
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          size,
    output logic [NUM_REGS-1:0] sel,
    output logic                err
);
    logic           hit;
    logic           want_half;
    logic [31:0]    idx;

    // Map an offset to a register index and its required width
    always_comb begin
        hit       = 1'b1;
        want_half = 1'b0;
        idx       = '0;
        if (addr == ADDR_W'(8'h00)) begin
            idx = REG_CMD;  want_half = 1'b1;
        end else if (addr == ADDR_W'(8'h04)) begin
            idx = REG_MASK; want_half = 1'b1;
        end else if (addr == ADDR_W'(8'h08)) begin
            idx = REG_STAT; want_half = 1'b1;
        end else if (addr == ADDR_W'(8'h0C)) begin
            idx = REG_TIME;
        end else begin
            hit = 1'b0;
            for (int k = 0; k < DATA_WORDS; k++) begin
                if (addr == ADDR_W'(DATA_BASE + 4 * k)) begin
                    hit = 1'b1;
                    idx = 32'(REG_DAT0 + k);
                end
            end
        end
    end

    // Rank the checks: illegal size, then missing register, then width mismatch
    always_comb begin
        if (size != SZ_HALF && size != SZ_WORD)
            err = 1'b1;
        else if (!hit)
            err = 1'b1;
        else if (want_half)
            err = (size != SZ_HALF);
        else
            err = (size != SZ_WORD);
        sel = err ? '0 : (NUM_REGS'(1) << idx);
    end
endmodule

// File: rtl/otp_byte_merge.sv
// Byte-lane selector: each output byte takes the new byte when its enable
// is set and the kept byte otherwise. Purely combinational.
module otp_byte_merge #(
    parameter int LANES = 16
) (
    input  logic [LANES*8-1:0] keep_in,
    input  logic [LANES*8-1:0] new_in,
    input  logic [LANES-1:0]   en,
    output logic [LANES*8-1:0] merged
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Choose the source for one byte lane
        assign merged[i*8 +: 8] = en[i] ? new_in[i*8 +: 8] : keep_in[i*8 +: 8];
    end
endmodule

// File: rtl/otp_page_store.sv
// Synchronous page array with per-byte write enables and a registered read port.
// Assumes write and read are never requested in the same cycle.
// Contents are not reset.
module otp_page_store #(
    parameter int PAGES = 512,
    parameter int LANES = 16,
    localparam int PA_W = $clog2(PAGES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [LANES-1:0]   wbe,
    input  logic               re,
    input  logic [PA_W-1:0]    addr,
    input  logic [LANES*8-1:0] wdata,
    output logic [LANES*8-1:0] rdata
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] cells [PAGES];

        // Store one byte lane when its enable is set
        always_ff @(posedge clk) begin
            if (we && wbe[i])
                cells[addr] <= wdata[i*8 +: 8];
        end

        // Register one byte lane of the read data
        always_ff @(posedge clk) begin
            if (!rst_n)
                rdata[i*8 +: 8] <= '0;
            else if (re)
                rdata[i*8 +: 8] <= cells[addr];
        end
    end

    // The sequencer orders write before read, never both at once
    assert_no_rw_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re));
endmodule

// File: rtl/otp_page_ctrl.sv
// OTP page-access controller top. It holds the register bank, serves
// single-beat bus accesses, and runs a command through the sequence
// page-write, page-read and load. Only one access is in flight at a time:
// req_ready is low while a command runs.
module otp_page_ctrl
    import otp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGES  = 512,
    localparam int PA_W   = $clog2(PAGES),
    localparam int DATA_W = PAGE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata
);
    seq_state_e             state_q;
    logic [15:0]            cmd_q;
    logic [15:0]            mask_q;
    logic [15:0]            stat_q;
    logic [31:0]            time_q;
    logic [DATA_W-1:0]      data_q;
    logic [NUM_REGS-1:0]    sel;
    logic                   dec_err;
    logic                   accept;
    logic                   wr_acc;
    logic [31:0]            rd_mux;
    logic [DATA_W-1:0]      page_rdata;
    logic [DATA_W-1:0]      data_merged;
    logic                   mem_we;
    logic                   mem_re;

    otp_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .size (req_size),
        .sel  (sel),
        .err  (dec_err)
    );

    otp_page_store #(.PAGES(PAGES), .LANES(PAGE_BYTES)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .wbe   (mask_q),
        .re    (mem_re),
        .addr  (cmd_q[PA_W-1:0]),
        .wdata (data_q),
        .rdata (page_rdata)
    );

    otp_byte_merge #(.LANES(PAGE_BYTES)) u_merge (
        .keep_in (data_q),
        .new_in  (page_rdata),
        .en      (mask_q),
        .merged  (data_merged)
    );

    // Handshake and array strobes follow the sequencer state
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign wr_acc    = accept && req_write && !dec_err;
    assign mem_we    = (state_q == ST_PWR) && cmd_q[CMD_WR_BIT];
    assign mem_re    = (state_q == ST_PRD) && cmd_q[CMD_RD_BIT];

    // Select the read value of the addressed register
    always_comb begin
        rd_mux = '0;
        if (sel[REG_CMD])  rd_mux = {16'h0, cmd_q};
        if (sel[REG_MASK]) rd_mux = {16'h0, mask_q};
        if (sel[REG_STAT]) rd_mux = {16'h0, stat_q};
        if (sel[REG_TIME]) rd_mux = time_q;
        for (int k = 0; k < DATA_WORDS; k++)
            if (sel[REG_DAT0 + k]) rd_mux = data_q[k*WORD_W +: WORD_W];
    end

    // Register bank, response generation and command sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cmd_q     <= '0;
            mask_q    <= MASK_RST;
            stat_q    <= '0;
            time_q    <= TIME_RST;
            data_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (dec_err) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                            rsp_rdata <= '0;
                        end else if (req_write) begin
                            rsp_rdata <= '0;
                            if (sel[REG_CMD]) begin
                                cmd_q   <= req_wdata[15:0] & CMD_KEEP_MASK;
                                state_q <= ST_PWR;
                            end else begin
                                rsp_valid <= 1'b1;
                            end
                            if (sel[REG_MASK]) mask_q <= req_wdata[15:0];
                            if (sel[REG_STAT]) stat_q <= stat_q & ~req_wdata[15:0];
                            if (sel[REG_TIME]) time_q <= req_wdata;
                            for (int k = 0; k < DATA_WORDS; k++)
                                if (sel[REG_DAT0 + k])
                                    data_q[k*WORD_W +: WORD_W] <= req_wdata;
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= rd_mux;
                        end
                    end
                end
                ST_PWR: state_q <= ST_PRD;
                ST_PRD: state_q <= ST_LOAD;
                ST_LOAD: begin
                    if (cmd_q[CMD_RD_BIT])
                        data_q <= data_merged;
                    stat_q[0] <= 1'b1;
                    rsp_valid <= 1'b1;
                    rsp_rdata <= '0;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // A rejected access leaves every software-visible register untouched
    assert_err_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (mask_q == $past(mask_q)) && (time_q == $past(time_q))
            && (data_q == $past(data_q)) && (cmd_q == $past(cmd_q))
            && (stat_q == $past(stat_q)));

    // The command register never holds bits outside its writable set
    assert_cmd_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q & ~CMD_KEEP_MASK) == 16'h0);

    // The data words change only on a direct write or on a command load
    assert_data_change_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_q != $past(data_q)) |-> ($past(wr_acc) || $past(state_q == ST_LOAD)));

    // The done flag rises only together with a successful response
    assert_done_on_response_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[0]) |-> (rsp_valid && !rsp_err));

    // A response answers either the last accepted access or a finished command
    assert_rsp_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(accept) || $past(state_q == ST_LOAD)));
endmodule

// File: tb/otp_page_ctrl_tb.sv
`timescale 1ns/100ps
// Self-checking bench: a vector table of register accesses, then directed
// command sequences for page transfers, ordering and status behaviour.
module otp_page_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    otp_page_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic        exp_err;
        logic        chk_rd;
        logic [31:0] exp_rd;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 8'h00, 2'd1, 32'h0,        1'b0, 1'b1, 32'h0000_0000}, // R1 command
        '{1'b0, 8'h04, 2'd1, 32'h0,        1'b0, 1'b1, 32'h0000_FFFF}, // R1 mask
        '{1'b0, 8'h08, 2'd1, 32'h0,        1'b0, 1'b1, 32'h0000_0000}, // R1 status
        '{1'b0, 8'h0C, 2'd2, 32'h0,        1'b0, 1'b1, 32'h0000_1485}, // R1 timing
        '{1'b0, 8'h80, 2'd2, 32'h0,        1'b0, 1'b1, 32'h0000_0000}, // R1 data0
        '{1'b0, 8'h8C, 2'd2, 32'h0,        1'b0, 1'b1, 32'h0000_0000}, // R1 data3
        '{1'b0, 8'h00, 2'd2, 32'h0,        1'b1, 1'b1, 32'h0000_0000}, // R2 cmd as word
        '{1'b0, 8'h0C, 2'd1, 32'h0,        1'b1, 1'b1, 32'h0000_0000}, // R2 timing as half
        '{1'b1, 8'h04, 2'd2, 32'h1234,     1'b1, 1'b0, 32'h0},         // R2 mask as word
        '{1'b0, 8'h04, 2'd1, 32'h0,        1'b0, 1'b1, 32'h0000_FFFF}, // R2 mask unchanged
        '{1'b1, 8'h84, 2'd1, 32'h5555,     1'b1, 1'b0, 32'h0},         // R2 data as half
        '{1'b0, 8'h84, 2'd2, 32'h0,        1'b0, 1'b1, 32'h0000_0000}, // R2 data unchanged
        '{1'b0, 8'h00, 2'd0, 32'h0,        1'b1, 1'b1, 32'h0000_0000}, // R2 byte size
        '{1'b0, 8'h80, 2'd3, 32'h0,        1'b1, 1'b1, 32'h0000_0000}, // R2 reserved size
        '{1'b0, 8'h10, 2'd2, 32'h0,        1'b1, 1'b1, 32'h0000_0000}, // R3 gap
        '{1'b1, 8'h40, 2'd2, 32'hFFFF_FFFF,1'b1, 1'b0, 32'h0},         // R3 gap write
        '{1'b0, 8'h82, 2'd1, 32'h0,        1'b1, 1'b1, 32'h0000_0000}, // R3 misaligned
        '{1'b0, 8'h90, 2'd2, 32'h0,        1'b1, 1'b1, 32'h0000_0000}, // R3 past data3
        '{1'b0, 8'h80, 2'd2, 32'h0,        1'b0, 1'b1, 32'h0000_0000}, // R3 data0 unchanged
        '{1'b1, 8'h0C, 2'd2, 32'hDEAD_BEEF,1'b0, 1'b0, 32'h0},         // R10 timing write
        '{1'b0, 8'h0C, 2'd2, 32'h0,        1'b0, 1'b1, 32'hDEAD_BEEF}, // R10 timing read
        '{1'b1, 8'h04, 2'd1, 32'h5A3C,     1'b0, 1'b0, 32'h0},         // R10 mask write
        '{1'b0, 8'h04, 2'd1, 32'h0,        1'b0, 1'b1, 32'h0000_5A3C}, // R10 mask read
        '{1'b1, 8'h04, 2'd1, 32'hFFFF,     1'b0, 1'b0, 32'h0}          // restore mask
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus access; lat counts falling edges from acceptance to response
    task automatic access(input logic w, input logic [7:0] a, input logic [1:0] s,
                          input logic [31:0] d, output logic [31:0] rd,
                          output logic er, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        er = rsp_err;
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d,
                      input string tag);
        logic [31:0] rd; logic er; int lat;
        access(1'b1, a, s, d, rd, er, lat);
        check({tag, " write err"}, 32'(er), 32'd0);
    endtask

    task automatic rdchk(input logic [7:0] a, input logic [1:0] s, input logic [31:0] exp,
                         input string tag);
        logic [31:0] rd; logic er; int lat;
        access(1'b0, a, s, 32'h0, rd, er, lat);
        check({tag, " read"}, rd, exp);
    endtask

    // Issue a command and check its four-cycle latency (R9)
    task automatic cmd(input logic [15:0] v, input string tag);
        logic [31:0] rd; logic er; int lat;
        access(1'b1, 8'h00, 2'd1, {16'h0, v}, rd, er, lat);
        check({tag, " R9 cmd latency"}, 32'(lat), 32'd4);
        check({tag, " R9 cmd err"}, 32'(er), 32'd0);
    endtask

    task automatic load_data(input logic [31:0] d0, d1, d2, d3);
        wr(8'h80, 2'd2, d0, "data0");
        wr(8'h84, 2'd2, d1, "data1");
        wr(8'h88, 2'd2, d2, "data2");
        wr(8'h8C, 2'd2, d3, "data3");
    endtask

    task automatic read_data(input logic [31:0] d0, d1, d2, d3, input string tag);
        rdchk(8'h80, 2'd2, d0, {tag, " data0"});
        rdchk(8'h84, 2'd2, d1, {tag, " data1"});
        rdchk(8'h88, 2'd2, d2, {tag, " data2"});
        rdchk(8'h8C, 2'd2, d3, {tag, " data3"});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd; logic er; int lat;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 ready after reset", 32'(req_ready), 32'd1);
        rst_n = 1'b1;

        // Table walk: register accesses, widths, unmapped offsets
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata, rd, er, lat);
            check($sformatf("vec%0d err (R2/R3)", i), 32'(er), 32'(VECS[i].exp_err));
            check($sformatf("vec%0d R9 latency", i), 32'(lat), 32'd1);
            if (VECS[i].chk_rd)
                check($sformatf("vec%0d rdata (R1/R10)", i), rd, VECS[i].exp_rd);
        end

        // R4: writable mask on command register; R8: done set
        cmd(16'hFFFF, "R4");
        rdchk(8'h00, 2'd1, 32'h0000_39FF, "R4 cmd mask");
        rdchk(8'h08, 2'd1, 32'h0000_0001, "R8 done set");
        wr(8'h08, 2'd1, 32'h0000_FFFE, "R8 w0");
        rdchk(8'h08, 2'd1, 32'h0000_0001, "R8 zero keeps");
        wr(8'h08, 2'd1, 32'h0000_0001, "R8 w1c");
        rdchk(8'h08, 2'd1, 32'h0000_0000, "R8 cleared");
        cmd(16'h0005, "R8 nocmd");
        rdchk(8'h08, 2'd1, 32'h0000_0001, "R8 done without command");
        wr(8'h08, 2'd1, 32'h0000_0001, "R8 clear");

        // R5/R6: full page write then read back into cleared registers
        load_data(32'h1122_3344, 32'h5566_7788, 32'h99AA_BBCC, 32'hDDEE_FF00);
        cmd(16'h1005, "R5 write p5");
        load_data(32'h0, 32'h0, 32'h0, 32'h0);
        cmd(16'h2005, "R6 read p5");
        read_data(32'h1122_3344, 32'h5566_7788, 32'h99AA_BBCC, 32'hDDEE_FF00, "R5 full");

        // R5: byte order, mask 0x8001 writes byte 0 and byte 15 only
        load_data(32'h0, 32'h0, 32'h0, 32'h0);
        cmd(16'h1007, "R5 clear p7");
        load_data(32'hAAAA_AAAA, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 32'hAAAA_AAAA);
        wr(8'h04, 2'd1, 32'h8001, "mask");
        cmd(16'h1007, "R5 partial p7");
        wr(8'h04, 2'd1, 32'hFFFF, "mask");
        load_data(32'h0, 32'h0, 32'h0, 32'h0);
        cmd(16'h2007, "R5 read p7");
        read_data(32'h0000_00AA, 32'h0, 32'h0, 32'hAA00_0000, "R5 byte order");

        // R6: partial read only updates bytes 4..7
        load_data(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        wr(8'h04, 2'd1, 32'h00F0, "mask");
        cmd(16'h2005, "R6 partial read p5");
        read_data(32'hFFFF_FFFF, 32'h5566_7788, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 partial");
        wr(8'h04, 2'd1, 32'hFFFF, "mask");

        // R7: with both bits, write precedes read
        load_data(32'h0101_0101, 32'h0202_0202, 32'h0303_0303, 32'h0404_0404);
        cmd(16'h1009, "R7 seed p9");
        load_data(32'hC0DE_0001, 32'hC0DE_0002, 32'hC0DE_0003, 32'hC0DE_0004);
        cmd(16'h3009, "R7 both p9");
        read_data(32'hC0DE_0001, 32'hC0DE_0002, 32'hC0DE_0003, 32'hC0DE_0004, "R7 regs");
        load_data(32'h0, 32'h0, 32'h0, 32'h0);
        cmd(16'h2009, "R7 reread p9");
        read_data(32'hC0DE_0001, 32'hC0DE_0002, 32'hC0DE_0003, 32'hC0DE_0004, "R7 page");

        // R9: ready is low while a command runs
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h00; req_size = 2'd1;
        req_wdata = 32'h0000_0009;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R9 ready low during command", 32'(req_ready), 32'd0);
        repeat (3) @(negedge clk);
        check("R9 ready back", 32'(req_ready), 32'd1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule